// File: doc/BRIEF.md
# CC Line State Reporter

This block turns the raw level class seen by the comparators on each of the two configuration-channel pins into a filtered, role-aware 2-bit state code. It packs both codes, a connection-search flag and a connect-result bit into one status byte. A level must hold steady for a programmable number of clock samples before it is reported. The code table each pin uses depends on whether that pin is acting as a source (pull-up) or as a sink (pull-down). Several conditions force a pin's code to zero.

Firmware-facing logic samples the status byte. It uses the one-cycle change pulse to raise an alert. A second one-cycle pulse marks the moment the search flag drops, which means a connection may have been found. The analog comparators, toggle sequencing and the register bus stay outside the block.

Top module: `cc_state_reporter`

## Requirements
- R1: `status_o` is `{2'b00, searching, conn_result, cc2_code, cc1_code}`. Bits 7:6 always read 0, bit 5 follows `searching`, and bit 4 follows `conn_result`.
- R2: Each pin has a debounce filter. A new raw class (`ccN_raw`) is reported only after it has been sampled unchanged on FILT_CYC+1 consecutive rising edges, and it appears on `status_o` one edge later. A change that lasts FILT_CYC edges or fewer is ignored.
- R3: Source table, for raw class 0 = open, 1 = low, 2 = mid, 3 = high: the code is 00 for open, 01 for low (Ra seen), 10 for mid (Rd seen), and 00 for high, so the reserved code 11 never appears.
- R4: Sink table: the code equals the raw class. 00 = open, 01 = default current, 10 = 1.5 A, 11 = 3.0 A.
- R5: With `drp_en`=0 the table comes from the pin role: role 1 (Rp) selects the source table and role 2 (Rd) selects the sink table. With `drp_en`=1, `conn_result`=0 selects the source table and `conn_result`=1 selects the sink table.
- R6: A pin whose role is 0 (open) or 3 (Ra) reports 00.
- R7: While `searching`=1, both pin codes report 00.
- R8: With `vconn_en`=1, the CC2 code reports 00 when `orient`=0, and the CC1 code reports 00 when `orient`=1.
- R9: A one-cycle `role_wr` pulse clears both filtered levels to open and restarts both filters. Held levels reappear after the full R2 window.
- R10: `status_chg` is high for exactly those cycles in which `status_o` differs from its value in the previous cycle.
- R11: `conn_found` is high for exactly one cycle when bit 5 of `status_o` goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cc1_role | input | 2 | CC1 role: 0 open, 1 Rp, 2 Rd, 3 Ra |
| cc2_role | input | 2 | CC2 role, same encoding |
| cc1_raw | input | 2 | CC1 raw level class (0..3) |
| cc2_raw | input | 2 | CC2 raw level class (0..3) |
| role_wr | input | 1 | Pulse: role setting was rewritten |
| drp_en | input | 1 | Table chosen by connect result, not role |
| conn_result | input | 1 | 0 presenting Rp, 1 presenting Rd |
| searching | input | 1 | Connection search in progress |
| vconn_en | input | 1 | VCONN supply enabled |
| orient | input | 1 | Plug orientation |
| status_o | output | 8 | Packed status byte |
| status_chg | output | 1 | One-cycle pulse on any byte change |
| conn_found | output | 1 | One-cycle pulse on search flag fall |

## Verification
The assertions assume that every input is driven to a known value from the first clock edge and is stable around each rising edge. They also assume that `role_wr` is a pulse rather than a held level, because a held `role_wr` keeps the filters cleared. The bench changes inputs only on falling edges and always releases `role_wr` after one cycle. Its sweep holds each input set for longer than the filter window, so every expected code is reached before it is compared.

// File: rtl/cc_rep_pkg.sv
package cc_rep_pkg;

   localparam int LVL_W  = 2;
   localparam int NPINS  = 2;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      ROLE_OPEN = 2'd0,
      ROLE_RP   = 2'd1,
      ROLE_RD   = 2'd2,
      ROLE_RA   = 2'd3
   } cc_role_e;

   // Source-side mapping: the top class has no source meaning, report open.
   function automatic logic [LVL_W-1:0] src_code(input logic [LVL_W-1:0] lvl);
      return (lvl == 2'd3) ? 2'd0 : lvl;
   endfunction

endpackage

// File: rtl/cc_debounce.sv
module cc_debounce #(
   parameter int FILT_CYC = 4,
   parameter int LVL_W    = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic [LVL_W-1:0] raw_i,
   output logic [LVL_W-1:0] stable_o
);
   localparam int CNT_W = $clog2(FILT_CYC);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(FILT_CYC - 1);

   if (FILT_CYC < 2) begin : g_bad_filt
      $error("cc_debounce: FILT_CYC must be at least 2");
   end

   logic [LVL_W-1:0] cand_q;
   logic [LVL_W-1:0] stab_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cand_q <= '0;
         stab_q <= '0;
         cnt_q  <= '0;
      end else if (restart) begin
         cand_q <= raw_i;
         stab_q <= '0;
         cnt_q  <= '0;
      end else if (raw_i != cand_q) begin
         cand_q <= raw_i;
         cnt_q  <= '0;
      end else if (cnt_q != LIM) begin
         cnt_q  <= cnt_q + 1'b1;
      end else begin
         stab_q <= cand_q;
      end
   end

   assign stable_o = stab_q;

   // R2: the filtered level only moves after a full quiet window on the candidate
   a_r2_window_done: assert property (@(posedge clk) disable iff (rst)
      (stab_q != $past(stab_q)) && !$past(restart)
         |-> ($past(cnt_q) == LIM) && ($past(cand_q) == stab_q));

   // R9: a restart returns the filtered level to open
   a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
      restart |=> (stab_q == '0));

endmodule

// File: rtl/cc_field_enc.sv
module cc_field_enc
   import cc_rep_pkg::*;
#(
   parameter int PIN_IDX = 0
) (
   input  logic [1:0]       role_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic             drp_en,
   input  logic             conn_result,
   input  logic             searching,
   input  logic             vconn_en,
   input  logic             orient,
   output logic [LVL_W-1:0] field_o
);
   if (PIN_IDX < 0 || PIN_IDX >= NPINS) begin : g_bad_idx
      $error("cc_field_enc: PIN_IDX out of range");
   end

   logic vconn_blank;

   // The pin carrying VCONN is the one opposite the orientation.
   if (PIN_IDX == 0) begin : g_pin_a
      assign vconn_blank = vconn_en & orient;
   end else begin : g_pin_b
      assign vconn_blank = vconn_en & ~orient;
   end

   cc_role_e role;
   logic     use_sink;
   logic     role_blank;

   always_comb begin
      role       = cc_role_e'(role_i);
      role_blank = (role == ROLE_OPEN) || (role == ROLE_RA);
      use_sink   = drp_en ? conn_result : (role == ROLE_RD);
      if (searching || vconn_blank || role_blank)
         field_o = '0;
      else if (use_sink)
         field_o = lvl_i;
      else
         field_o = src_code(lvl_i);
   end

endmodule

// File: rtl/cc_status_pack.sv
module cc_status_pack
   import cc_rep_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic [LVL_W-1:0]  cc1_f,
   input  logic [LVL_W-1:0]  cc2_f,
   input  logic              srch,
   input  logic              cres,
   output logic [BYTE_W-1:0] status_o,
   output logic              chg_o,
   output logic              found_o
);
   localparam int SRCH_BIT = 2 * LVL_W + 1;

   logic [BYTE_W-1:0] nxt;
   logic [BYTE_W-1:0] stat_q;
   logic              chg_q;
   logic              found_q;

   assign nxt = {2'b00, srch, cres, cc2_f, cc1_f};

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q  <= '0;
         chg_q   <= 1'b0;
         found_q <= 1'b0;
      end else begin
         stat_q  <= nxt;
         chg_q   <= (nxt != stat_q);
         found_q <= stat_q[SRCH_BIT] & ~nxt[SRCH_BIT];
      end
   end

   assign status_o = stat_q;
   assign chg_o    = chg_q;
   assign found_o  = found_q;

   // R10: pulse means the byte moved
   a_r10_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
      chg_o |-> (status_o != $past(status_o)));

   // R10: no pulse means the byte held
   a_r10_quiet_when_held: assert property (@(posedge clk) disable iff (rst)
      !chg_o |-> $stable(status_o));

   // R11: found pulse only on a falling search bit
   a_r11_found_on_fall: assert property (@(posedge clk) disable iff (rst)
      found_o |-> ($past(status_o[SRCH_BIT]) && !status_o[SRCH_BIT]));

endmodule

// File: rtl/cc_state_reporter.sv
module cc_state_reporter
   import cc_rep_pkg::*;
#(
   parameter int FILT_CYC = 8
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] cc1_role,
   input  logic [1:0] cc2_role,
   input  logic [1:0] cc1_raw,
   input  logic [1:0] cc2_raw,
   input  logic       role_wr,
   input  logic       drp_en,
   input  logic       conn_result,
   input  logic       searching,
   input  logic       vconn_en,
   input  logic       orient,
   output logic [7:0] status_o,
   output logic       status_chg,
   output logic       conn_found
);
   if (FILT_CYC < 2) begin : g_bad_filt
      $error("cc_state_reporter: FILT_CYC must be at least 2");
   end

   logic [1:0]       role_a [NPINS];
   logic [LVL_W-1:0] raw_a  [NPINS];
   logic [LVL_W-1:0] stab_a [NPINS];
   logic [LVL_W-1:0] fld_a  [NPINS];

   assign role_a[0] = cc1_role;
   assign role_a[1] = cc2_role;
   assign raw_a[0]  = cc1_raw;
   assign raw_a[1]  = cc2_raw;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      cc_debounce #(
         .FILT_CYC (FILT_CYC),
         .LVL_W    (LVL_W)
      ) u_deb (
         .clk      (clk),
         .rst      (rst),
         .restart  (role_wr),
         .raw_i    (raw_a[p]),
         .stable_o (stab_a[p])
      );

      cc_field_enc #(
         .PIN_IDX (p)
      ) u_enc (
         .role_i      (role_a[p]),
         .lvl_i       (stab_a[p]),
         .drp_en      (drp_en),
         .conn_result (conn_result),
         .searching   (searching),
         .vconn_en    (vconn_en),
         .orient      (orient),
         .field_o     (fld_a[p])
      );
   end

   cc_status_pack u_pack (
      .clk      (clk),
      .rst      (rst),
      .cc1_f    (fld_a[0]),
      .cc2_f    (fld_a[1]),
      .srch     (searching),
      .cres     (conn_result),
      .status_o (status_o),
      .chg_o    (status_chg),
      .found_o  (conn_found)
   );

   // R7: search blanks both codes
   a_r7_search_blank: assert property (@(posedge clk) disable iff (rst)
      $past(searching) |-> (status_o[3:0] == 4'd0));

   // R8: VCONN pin blanked according to orientation
   a_r8_vconn_cc2: assert property (@(posedge clk) disable iff (rst)
      $past(vconn_en && !orient) |-> (status_o[3:2] == 2'd0));
   a_r8_vconn_cc1: assert property (@(posedge clk) disable iff (rst)
      $past(vconn_en && orient) |-> (status_o[1:0] == 2'd0));

   // R6: open or Ra role on CC1 reports zero
   a_r6_passive_role: assert property (@(posedge clk) disable iff (rst)
      $past(cc1_role == 2'd0 || cc1_role == 2'd3) |-> (status_o[1:0] == 2'd0));

   // R3: the source table never yields the reserved code
   a_r3_no_reserved: assert property (@(posedge clk) disable iff (rst)
      $past(!drp_en && cc1_role == 2'd1) |-> (status_o[1:0] != 2'd3));

   // R1: the flag bits track their inputs one cycle later
   a_r1_flags_follow: assert property (@(posedge clk) disable iff (rst)
      (status_o[5:4] == $past({searching, conn_result})) && (status_o[7:6] == 2'd0));

endmodule

// File: tb/sim_cc_state_reporter.sv
module sim_cc_state_reporter;
   localparam int CLK_PER = 10;
   localparam int FILT    = 4;
   localparam int WD_CYC  = 190000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] cc1_role = '0, cc2_role = '0, cc1_raw = '0, cc2_raw = '0;
   logic       role_wr = 1'b0, drp_en = 1'b0, conn_result = 1'b0;
   logic       searching = 1'b0, vconn_en = 1'b0, orient = 1'b0;
   logic [7:0] status_o;
   logic       status_chg, conn_found;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;
   bit mon_on = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   cc_state_reporter #(.FILT_CYC(FILT)) u0 (
      .clk(clk), .rst(rst), .cc1_role(cc1_role), .cc2_role(cc2_role),
      .cc1_raw(cc1_raw), .cc2_raw(cc2_raw), .role_wr(role_wr),
      .drp_en(drp_en), .conn_result(conn_result), .searching(searching),
      .vconn_en(vconn_en), .orient(orient), .status_o(status_o),
      .status_chg(status_chg), .conn_found(conn_found));

   function automatic logic [1:0] exp_fld(input logic [1:0] role, input logic [1:0] lvl,
                                          input logic drp, input logic cr, input logic srch,
                                          input logic vc, input logic ori, input int idx);
      logic sink;
      if (srch) return 2'd0;
      if (vc && (ori != idx[0])) return 2'd0;
      if (role == 2'd0 || role == 2'd3) return 2'd0;
      sink = drp ? cr : (role == 2'd2);
      if (sink) return lvl;
      return (lvl == 2'd3) ? 2'd0 : lvl;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R10 / R11 per-cycle monitor
   logic [7:0] prev_s;
   always @(negedge clk) begin
      if (mon_on && !done) begin
         check("R10 change pulse", {7'd0, status_chg}, {7'd0, status_o != prev_s});
         check("R11 found pulse", {7'd0, conn_found}, {7'd0, prev_s[5] & ~status_o[5]});
      end
      prev_s = status_o;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(3);
      // reset state
      check("R1 reset status", status_o, 8'h00);
      check("R10 reset pulse", {6'd0, status_chg, conn_found}, 8'h00);
      rst = 1'b0;
      tick(1);
      mon_on = 1'b1;

      // R2 timing: both Rd, sink table
      cc1_role = 2'd2; cc2_role = 2'd2;
      tick(FILT + 4);
      cc1_raw = 2'd2;
      tick(FILT + 1);
      check("R2 not yet reported", status_o, 8'h00);
      tick(1);
      check("R2 reported after window", status_o, 8'h02);

      // R2 short glitch ignored
      cc1_raw = 2'd3;
      tick(FILT);
      cc1_raw = 2'd2;
      tick(FILT + 4);
      check("R2 glitch ignored", status_o, 8'h02);

      // R9 role write clears and restarts
      role_wr = 1'b1;
      tick(1);
      role_wr = 1'b0;
      tick(1);
      check("R9 cleared after role write", status_o, 8'h00);
      tick(FILT - 1);
      check("R9 still held during window", status_o, 8'h00);
      tick(1);
      check("R9 restored after window", status_o, 8'h02);

      // R11 explicit: search rise then fall
      searching = 1'b1;
      tick(2);
      check("R7 search blanks", status_o, 8'h20);
      searching = 1'b0;
      tick(1);
      check("R11 found pulse seen", {7'd0, conn_found}, 8'h01);
      tick(1);
      check("R11 found pulse single", {7'd0, conn_found}, 8'h00);

      // Exhaustive sweep: R1 R3 R4 R5 R6 R7 R8
      for (int r1 = 0; r1 < 4; r1++)
      for (int r2 = 0; r2 < 4; r2++)
      for (int cb = 0; cb < 32; cb++)
      for (int l1 = 0; l1 < 4; l1++)
      for (int l2 = 0; l2 < 4; l2++) begin
         logic [7:0] e;
         cc1_role = 2'(r1); cc2_role = 2'(r2);
         cc1_raw = 2'(l1);  cc2_raw = 2'(l2);
         drp_en = cb[0]; conn_result = cb[1]; searching = cb[2];
         vconn_en = cb[3]; orient = cb[4];
         tick(FILT + 3);
         e = {2'b00, cb[2], cb[1],
              exp_fld(2'(r2), 2'(l2), cb[0], cb[1], cb[2], cb[3], cb[4], 1),
              exp_fld(2'(r1), 2'(l1), cb[0], cb[1], cb[2], cb[3], cb[4], 0)};
         check("R1 R3 R4 R5 R6 R7 R8 sweep", status_o, e);
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule